// File: doc/BRIEF.md
# Three-Channel Checksummed 2-of-4 Symbol Decoder

This block sits behind three parallel four-wire receivers whose every legal symbol has exactly two wires high. The six legal symbols fall into three pairs, each pair being a symbol and its bitwise complement, and the pair index (a trit) carries data. The third channel's pair index is a checksum chosen so the three indices add to zero modulo 3. The pick of member inside each pair carries one further data bit per channel.

Each clock the decoder accepts one 12-wire word with a valid strobe. It marks every channel whose weight is not two. When exactly one channel is bad, it rebuilds that channel's pair index from the checksum and keeps whichever pair member lies nearer in Hamming distance. It then returns six data bits, or flags the word as uncorrectable when the damage is beyond repair. There are two pipeline stages: classification, then repair and output.

Top module: `csd_decoder`

## Requirements
- R1: A word presented with `in_valid` high at clock edge n yields `out_valid` high after edge n+2 for exactly one cycle per word, and back-to-back words are accepted every cycle.
- R2: Channel i occupies `in_wires[4i+3:4i]`. Pair index 0 is {0011,1100}, 1 is {0101,1010} and 2 is {0110,1001}. For a word with three weight-2 channels whose indices sum to 0 mod 3, `out_data[2:0]` = 3·t0 + t1 and `out_data[3+i]` is 1 exactly when channel i holds the member with bit 3 set. Both flags stay low.
- R3: When exactly one channel has weight 1 or 3, its pair index is taken as the value that brings the three-index sum to 0 mod 3. The member nearer to the received wires is kept, the data is decoded as in R2, and `out_corrected` is high.
- R4: When exactly one channel has weight 0 or 4, both members are equally near, so `out_uncorr` is high.
- R5: When two or more channels have a weight other than 2, `out_uncorr` is high.
- R6: When all channels have weight 2 but the pair indices do not sum to 0 mod 3, `out_uncorr` is high.
- R7: When the decoded (or repaired) indices give t0 = t1 = 2, `out_uncorr` is high, even if a repair took place.
- R8: `out_corrected` and `out_uncorr` are never high together. `out_data` is 0 whenever `out_uncorr` is high. All outputs are 0 while `out_valid` is low and during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A word is present on `in_wires` |
| in_wires | input | 12 | Three 4-wire channel symbols, channel 0 in the low nibble |
| out_valid | output | 1 | Decoded result is present |
| out_data | output | 6 | Recovered data bits |
| out_corrected | output | 1 | One channel was repaired |
| out_uncorr | output | 1 | Word could not be decoded |

## Verification
Single-channel repair and detection of an unmapped index pair can arise in the same word. This happens when a damaged channel is rebuilt into pair index 2 while the other data channel also holds index 2. The bench provokes this with a one-bit flip in channel 0 of the all-index-2 word. It then judges that the unmapped detection prevails: uncorrectable high, corrected low and data zero. The same bench also checks the plain unmapped word without damage, and a repaired word whose indices are mapped, so that each function is seen on its own.

// File: rtl/csd_pkg.sv
package csd_pkg;
  parameter int CH_N     = 3;                     // parallel channels
  parameter int SYM_W    = 4;                     // wires per channel
  parameter int ONES     = 2;                     // high wires per legal symbol
  parameter int TRIT_W   = 2;
  parameter int LOW_W    = 3;                     // bits carried by index pair
  parameter int MAP_MAX  = 7;                     // largest mapped 3*t0+t1
  localparam int DATA_W  = LOW_W + CH_N;
  localparam int WIRE_W  = CH_N * SYM_W;
  localparam int CNT_W   = $clog2(CH_N + 1);
  localparam int IDX_W   = $clog2(CH_N);
  localparam int WGT_W   = $clog2(SYM_W + 1);
  localparam int CODE_W  = 4;

  typedef struct packed {
    logic [SYM_W-1:0]  sym;
    logic              ok;
    logic [TRIT_W-1:0] subset;
    logic              hi;
  } ch_info_t;

  function automatic logic [WGT_W-1:0] sym_weight(logic [SYM_W-1:0] s);
    logic [WGT_W-1:0] n;
    n = '0;
    for (int b = 0; b < SYM_W; b++) n = n + {{(WGT_W-1){1'b0}}, s[b]};
    return n;
  endfunction

  function automatic logic [WGT_W-1:0] hamming(logic [SYM_W-1:0] a, logic [SYM_W-1:0] b);
    return sym_weight(a ^ b);
  endfunction

  // lower member of each pair has bit 3 clear
  function automatic logic [SYM_W-1:0] low_member(logic [TRIT_W-1:0] t);
    case (t)
      2'd0:    return 4'b0011;
      2'd1:    return 4'b0101;
      default: return 4'b0110;
    endcase
  endfunction

  function automatic logic [TRIT_W-1:0] sym_subset(logic [SYM_W-1:0] s);
    logic [SYM_W-1:0] lo;
    lo = s[SYM_W-1] ? ~s : s;
    case (lo)
      4'b0011: return 2'd0;
      4'b0101: return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

  function automatic logic [TRIT_W-1:0] trit_add(logic [TRIT_W-1:0] a, logic [TRIT_W-1:0] b);
    logic [TRIT_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= 3'd3) s = s - 3'd3;
    return s[TRIT_W-1:0];
  endfunction

  function automatic logic [TRIT_W-1:0] trit_neg(logic [TRIT_W-1:0] a);
    return (a == 2'd0) ? 2'd0 : (2'd3 - a);
  endfunction
endpackage

// File: rtl/csd_classify.sv
module csd_classify
  import csd_pkg::*;
(
  input  logic [SYM_W-1:0] sym,
  output ch_info_t         info
);
  logic [WGT_W-1:0] wgt;

  always_comb begin
    wgt         = sym_weight(sym);
    info.sym    = sym;
    info.ok     = (wgt == WGT_W'(ONES));
    info.subset = sym_subset(sym);
    info.hi     = sym[SYM_W-1];
  end
endmodule

// File: rtl/csd_repair.sv
module csd_repair
  import csd_pkg::*;
(
  input  ch_info_t            info [CH_N],
  output logic [DATA_W-1:0]   data,
  output logic                corrected,
  output logic                uncorr,
  output logic [CNT_W-1:0]    nbad,
  output logic [IDX_W-1:0]    bad_idx,
  output logic                sum_ok,
  output logic                tie,
  output logic                unmapped,
  output logic [TRIT_W-1:0]   fix_sub,
  output logic                fix_hi
);
  logic [TRIT_W-1:0] sum_all, others, t0, t1;
  logic [SYM_W-1:0]  bad_sym, lo_m;
  logic [WGT_W-1:0]  d_lo, d_hi;
  logic [CODE_W-1:0] code;
  logic              single;
  logic [CH_N-1:0]   hi_use;

  always_comb begin
    nbad    = '0;
    bad_idx = '0;
    sum_all = '0;
    others  = '0;
    bad_sym = '0;
    for (int i = CH_N - 1; i >= 0; i--)
      if (!info[i].ok) bad_idx = IDX_W'(i);
    for (int i = 0; i < CH_N; i++) begin
      nbad    = nbad + {{(CNT_W-1){1'b0}}, ~info[i].ok};
      sum_all = trit_add(sum_all, info[i].subset);
      if (IDX_W'(i) != bad_idx) others = trit_add(others, info[i].subset);
      else                      bad_sym = info[i].sym;
    end
    sum_ok  = (sum_all == '0);
    single  = (nbad == CNT_W'(1));
    // checksum restores the lost pair index
    fix_sub = trit_neg(others);
    lo_m    = low_member(fix_sub);
    d_lo    = hamming(bad_sym, lo_m);
    d_hi    = hamming(bad_sym, ~lo_m);
    tie     = (d_lo == d_hi);
    fix_hi  = (d_hi < d_lo);

    t0 = (single && bad_idx == IDX_W'(0)) ? fix_sub : info[0].subset;
    t1 = (single && bad_idx == IDX_W'(1)) ? fix_sub : info[1].subset;
    for (int i = 0; i < CH_N; i++)
      hi_use[i] = (single && bad_idx == IDX_W'(i)) ? fix_hi : info[i].hi;

    code     = {2'b00, t0} * CODE_W'(3) + {2'b00, t1};
    unmapped = (code > CODE_W'(MAP_MAX));

    uncorr    = (nbad > CNT_W'(1)) || (single && tie) ||
                (nbad == '0 && !sum_ok) || unmapped;
    corrected = single && !uncorr;
    data      = uncorr ? '0 : {hi_use, code[LOW_W-1:0]};
  end
endmodule

// File: rtl/csd_decoder.sv
module csd_decoder
  import csd_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [WIRE_W-1:0]   in_wires,
  output logic                out_valid,
  output logic [DATA_W-1:0]   out_data,
  output logic                out_corrected,
  output logic                out_uncorr
);
  ch_info_t cls     [CH_N];
  ch_info_t s1_info [CH_N];
  logic     s1_valid;

  // stage 1: per-channel weight and pair classification
  for (genvar g = 0; g < CH_N; g++) begin : g_ch
    csd_classify u_cls (
      .sym  (in_wires[g*SYM_W +: SYM_W]),
      .info (cls[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      for (int i = 0; i < CH_N; i++) s1_info[i] <= '0;
    end else begin
      s1_valid <= in_valid;
      for (int i = 0; i < CH_N; i++) s1_info[i] <= cls[i];
    end
  end

  // stage 2: repair and data recovery
  logic [DATA_W-1:0] rep_data;
  logic              rep_corr, rep_unc, rep_sum_ok, rep_tie, rep_unmapped, rep_fix_hi;
  logic [CNT_W-1:0]  rep_nbad;
  logic [IDX_W-1:0]  rep_bad_idx;
  logic [TRIT_W-1:0] rep_fix_sub;

  csd_repair u_rep (
    .info      (s1_info),
    .data      (rep_data),
    .corrected (rep_corr),
    .uncorr    (rep_unc),
    .nbad      (rep_nbad),
    .bad_idx   (rep_bad_idx),
    .sum_ok    (rep_sum_ok),
    .tie       (rep_tie),
    .unmapped  (rep_unmapped),
    .fix_sub   (rep_fix_sub),
    .fix_hi    (rep_fix_hi)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || !s1_valid) begin
      out_valid     <= 1'b0;
      out_data      <= '0;
      out_corrected <= 1'b0;
      out_uncorr    <= 1'b0;
    end else begin
      out_valid     <= 1'b1;
      out_data      <= rep_data;
      out_corrected <= rep_corr;
      out_uncorr    <= rep_unc;
    end
  end

  // R1
  in_to_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> s1_valid);
  // R1
  stage_to_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> out_valid);
  // R1
  no_spurious_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> !out_valid);
  // R3
  corr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_corrected |-> $past(rep_nbad) == CNT_W'(1));
  // R4
  tie_unc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && rep_nbad == CNT_W'(1) && rep_tie) |=> out_uncorr);
  // R5
  multi_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && rep_nbad > CNT_W'(1)) |=> out_uncorr);
  // R6
  sum_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && rep_nbad == '0 && !rep_sum_ok) |=> out_uncorr);
  // R7
  unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && rep_unmapped) |=> (out_uncorr && !out_corrected));
  // R8
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_corrected && out_uncorr));
  // R8
  unc_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_uncorr |-> out_data == '0);
  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_data == '0 && !out_corrected && !out_uncorr));
endmodule

// File: tb/test_csd_decoder.sv
module test_csd_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [11:0] in_wires = '0;
  logic        out_valid;
  logic [5:0]  out_data;
  logic        out_corrected;
  logic        out_uncorr;

  int n_run = 0;
  int n_fail = 0;

  csd_decoder i_csd_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_wires(in_wires),
    .out_valid(out_valid), .out_data(out_data),
    .out_corrected(out_corrected), .out_uncorr(out_uncorr)
  );

  always #5 clk = ~clk;

  function automatic logic [3:0] pair_base(int t);
    if (t == 0) return 4'b0011;
    if (t == 1) return 4'b0101;
    return 4'b0110;
  endfunction

  function automatic logic [11:0] encode(logic [5:0] d);
    int v, tr[3];
    logic [11:0] w;
    v = int'(d[2:0]);
    tr[0] = v / 3;
    tr[1] = v % 3;
    tr[2] = (6 - tr[0] - tr[1]) % 3;
    for (int i = 0; i < 3; i++) begin
      w[4*i +: 4] = d[3+i] ? ~pair_base(tr[i]) : pair_base(tr[i]);
    end
    return w;
  endfunction

  task automatic chk(string req, logic v, logic [5:0] d, logic c, logic u);
    n_run++;
    if (out_valid !== v || out_data !== d || out_corrected !== c || out_uncorr !== u) begin
      n_fail++;
      $display("FAIL %s: got v=%0b d=%02h c=%0b u=%0b, expected v=%0b d=%02h c=%0b u=%0b",
               req, out_valid, out_data, out_corrected, out_uncorr, v, d, c, u);
    end
  endtask

  // drive one word, sample the result two edges later
  task automatic send(logic [11:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_wires = w;
    @(negedge clk);
    in_valid = 1'b0;
    in_wires = '0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R8 reset", 1'b0, 6'h00, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R8 idle after reset", 1'b0, 6'h00, 1'b0, 1'b0);
  endtask

  task automatic t_stream();
    for (int k = 0; k < 66; k++) begin
      @(negedge clk);
      if (k >= 2) chk("R1 R2 stream", 1'b1, 6'(k - 2), 1'b0, 1'b0);
      in_valid = (k < 64);
      in_wires = (k < 64) ? encode(6'(k)) : 12'h000;
    end
    in_valid = 1'b0;
    @(negedge clk);
    chk("R1 valid drops", 1'b0, 6'h00, 1'b0, 1'b0);
  endtask

  task automatic t_single_fix();
    logic [5:0] set [5] = '{6'd0, 6'd5, 6'd13, 6'd42, 6'd63};
    foreach (set[j]) begin
      for (int ch = 0; ch < 3; ch++) begin
        for (int b = 0; b < 4; b++) begin
          logic [11:0] w;
          w = encode(set[j]);
          w[4*ch + b] = ~w[4*ch + b];
          send(w);
          chk("R3 single flip", 1'b1, set[j], 1'b1, 1'b0);
        end
      end
    end
  endtask

  task automatic t_worked_example();
    // ch0 1101 bad, ch1 0101 (index 1), ch2 1100 (index 0) -> ch0 1001
    send({4'b1100, 4'b0101, 4'b1101});
    chk("R3 nearest member", 1'b1, 6'b101111, 1'b1, 1'b0);
    @(negedge clk);
    chk("R1 single pulse", 1'b0, 6'h00, 1'b0, 1'b0);
  endtask

  task automatic t_tie();
    logic [11:0] w;
    w = encode(6'd20);
    w[7:4] = 4'b0000;
    send(w);
    chk("R4 weight 0", 1'b1, 6'h00, 1'b0, 1'b1);
    w = encode(6'd33);
    w[11:8] = 4'b1111;
    send(w);
    chk("R4 weight 4", 1'b1, 6'h00, 1'b0, 1'b1);
  endtask

  task automatic t_multi();
    logic [11:0] w;
    w = encode(6'd9);
    w[0] = ~w[0];
    w[9] = ~w[9];
    send(w);
    chk("R5 two bad", 1'b1, 6'h00, 1'b0, 1'b1);
    w = encode(6'd50);
    w[1] = ~w[1];
    w[4] = ~w[4];
    w[8] = ~w[8];
    send(w);
    chk("R5 three bad", 1'b1, 6'h00, 1'b0, 1'b1);
  endtask

  task automatic t_sum();
    // 0011,0011,0101: indices 0,0,1 -> sum 1
    send({4'b0101, 4'b0011, 4'b0011});
    chk("R6 bad checksum", 1'b1, 6'h00, 1'b0, 1'b1);
    send({4'b0110, 4'b1010, 4'b0101});
    chk("R6 bad checksum 2", 1'b1, 6'h00, 1'b0, 1'b1);
  endtask

  task automatic t_unmapped();
    send({4'b0110, 4'b0110, 4'b0110});
    chk("R7 unmapped clean", 1'b1, 6'h00, 1'b0, 1'b1);
    send({4'b0110, 4'b0110, 4'b0111});
    chk("R7 unmapped after repair", 1'b1, 6'h00, 1'b0, 1'b1);
    send({4'b0110, 4'b1101, 4'b1001});
    chk("R7 repaired index 2 into ch1", 1'b1, 6'h00, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_stream();
    t_single_fix();
    t_worked_example();
    t_tie();
    t_multi();
    t_sum();
    t_unmapped();
    @(negedge clk);
    chk("R8 quiet at end", 1'b0, 6'h00, 1'b0, 1'b0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule